// File: doc/BRIEF.md
# Frame-Based Time-Slot Switch with Message Channels

This block switches byte-wide time slots between a frame of incoming channels and a smaller set of outgoing channels. One input byte arrives per clock, in slot order. Each byte is stored in a data memory that has two banks, one per frame. While one bank fills with the current frame, the other bank still holds the whole previous frame. The outgoing channels are served from that previous frame. The banks change roles at every frame boundary.

Each outgoing channel has an entry in a connection table. The entry holds an 8-bit low byte and a 3-bit high part. The high part carries a message flag, a transfer-enable flag and the ninth source-address bit. When the message flag is clear, the nine address bits pick a source slot, and that slot's byte is sent. When the flag is set, the low byte itself is sent as a fixed message.

A processor port writes and reads both halves of every entry. Changes go into a staging copy of the table. The whole staging copy moves into the working copy only at a frame boundary, so a connection never changes partway through a frame. A per-channel transfer-enable vector, gated by a global enable input, is also produced for an external transfer engine.

Top module: `tsi_switch`

## Requirements
- R1: After reset every connection entry reads back as zero, `xfer_en` is all zero, and `out_valid` stays low for the whole first frame (slots 0 to NUM_SRC-1 after reset release).
- R2: With the message flag clear and a source address below NUM_SRC, channel c sends the byte that arrived in source slot {hi[0], lo} during the previous frame.
- R3: High-part bit 0 is source address bit 8, so source slots 256 to NUM_SRC-1 are reached by setting it.
- R4: A source address of NUM_SRC or more (with the message flag clear) makes the channel send 8'hFF.
- R5: When high-part bit 2 (message flag) is set, the channel sends its low byte unchanged, whatever the address bits hold.
- R6: `xfer_en[c]` is 1 exactly when high-part bit 1 of the working entry c is set and `dma_en` was 1 at the previous clock edge. It has one cycle of latency.
- R7: A processor write changes the staging copy at once but has no effect on outputs or on `xfer_en` until the next frame boundary.
- R8: Readback has a latency of one cycle. With `cpu_hi`=0 it returns the low byte. With `cpu_hi`=1 it returns {5'b0, message, enable, addr8}. A high write keeps only `cpu_wdata[2:0]`.
- R9: From the second frame on, channel c is sent while `cur_slot` equals c+2, tagged by `out_chan`=c. Channels go out in ascending order, exactly NUM_OUT per frame.
- R10: At every frame boundary the write bank changes and `cur_slot` returns to 0. Outputs always come from a complete earlier frame, even when the source slot comes after the output slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Input byte for the slot shown on `cur_slot` |
| cur_slot | output | SW | Current slot within the frame |
| dma_en | input | 1 | Global transfer enable |
| cpu_we | input | 1 | Connection entry write strobe |
| cpu_hi | input | 1 | Selects the high part (1) or the low byte (0) |
| cpu_addr | input | CW | Output channel entry index |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered readback of the staging entry |
| out_valid | output | 1 | Output byte present this cycle |
| out_chan | output | CW | Output channel of `out_byte` |
| out_byte | output | 8 | Switched or message byte |
| xfer_en | output | NUM_OUT | Per-channel gated transfer enable |

## Verification
Some properties are checked on every cycle by assertions:
- the transfer-enable gating;
- the working table holding still between boundaries;
- the message and invalid-address selections as they pass from the first pipeline stage to the output;
- strict ascending channel order;
- the bank toggle at each wrap.

Other behaviour can only be shown by the bench's scenarios, because it depends on what arrived a full frame earlier:
- that the switched byte is the correct earlier-frame byte;
- that the ninth address bit reaches the upper slots;
- that a write mid-frame is deferred to the next frame;
- the readback formats.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int SRC_W = 9;   // source address width: 8 low bits + 1 high bit

  typedef struct packed {
    logic       msg;     // high bit 2
    logic       ce;      // high bit 1
    logic       a8;      // high bit 0
    logic [7:0] lo;      // message byte or source address bits 7..0
  } conn_entry_t;

  function automatic logic [7:0] hi_bits(input conn_entry_t e);
    return {5'b0, e.msg, e.ce, e.a8};
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
  parameter int NUM_SRC = 384,
  localparam int SW = $clog2(NUM_SRC)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot,
  output logic          wr_bank,
  output logic          swap,
  output logic          primed
);
  localparam logic [SW-1:0] LAST = SW'(NUM_SRC - 1);

  assign swap = (slot == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot    <= '0;
      wr_bank <= 1'b0;
      primed  <= 1'b0;
    end else if (swap) begin
      slot    <= '0;
      wr_bank <= ~wr_bank;
      primed  <= 1'b1;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  // R10: bank toggles and slot restarts at every wrap
  p_bank_swap_r10: assert property (@(posedge clk) disable iff (rst)
    swap |=> (wr_bank != $past(wr_bank)) && (slot == '0));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int NUM_SRC = 384,
  localparam int SW  = $clog2(NUM_SRC),
  localparam int DEP = 2 * NUM_SRC,
  localparam int AW  = $clog2(DEP)
) (
  input  logic          clk,
  input  logic          wbank,
  input  logic [SW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          rbank,
  input  logic [SW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0]    mem [DEP];
  logic [AW-1:0] widx, ridx;

  assign widx = AW'(waddr) + (wbank ? AW'(NUM_SRC) : '0);
  assign ridx = AW'(raddr) + (rbank ? AW'(NUM_SRC) : '0);

  always_ff @(posedge clk) begin
    mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int NUM_OUT = 128,
  localparam int CW = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_we,
  input  logic               cpu_hi,
  input  logic [CW-1:0]      cpu_addr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  input  logic               swap,
  input  logic               dma_en,
  input  logic [CW-1:0]      rd_chan,
  output conn_entry_t        rd_entry,
  output logic [NUM_OUT-1:0] xfer_en
);
  conn_entry_t stage_q [NUM_OUT];
  conn_entry_t work_q  [NUM_OUT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_OUT; i++) begin
        stage_q[i] <= '0;
        work_q[i]  <= '0;
      end
    end else begin
      if (swap) begin
        for (int i = 0; i < NUM_OUT; i++) work_q[i] <= stage_q[i];
      end
      if (cpu_we) begin
        if (cpu_hi) begin
          stage_q[cpu_addr].msg <= cpu_wdata[2];
          stage_q[cpu_addr].ce  <= cpu_wdata[1];
          stage_q[cpu_addr].a8  <= cpu_wdata[0];
        end else begin
          stage_q[cpu_addr].lo  <= cpu_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= cpu_hi ? hi_bits(stage_q[cpu_addr]) : stage_q[cpu_addr].lo;
  end

  assign rd_entry = work_q[rd_chan];

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_xfer
    always_ff @(posedge clk) begin
      if (rst) xfer_en[g] <= 1'b0;
      else     xfer_en[g] <= work_q[g].ce & dma_en;
    end

    // R7: working entries change only at a frame boundary
    p_work_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !swap |=> $stable(work_q[g]));
  end

  // R6: no channel transfer without the global enable
  p_xfer_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (|xfer_en) |-> $past(dma_en));
endmodule

// File: rtl/tsi_out_sel.sv
module tsi_out_sel
  import tsi_pkg::*;
#(
  parameter int NUM_SRC = 384,
  parameter int NUM_OUT = 128,
  localparam int SW = $clog2(NUM_SRC),
  localparam int CW = $clog2(NUM_OUT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [CW-1:0] chan,
  input  logic          e_msg,
  input  logic          e_a8,
  input  logic [7:0]    e_lo,
  output logic [SW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic          out_valid,
  output logic [CW-1:0] out_chan,
  output logic [7:0]    out_byte
);
  localparam logic [SRC_W:0] LIMIT = (SRC_W + 1)'(NUM_SRC);

  logic [SRC_W-1:0] src;
  logic             bad;

  assign src       = {e_a8, e_lo};
  assign bad       = ({1'b0, src} >= LIMIT);
  assign mem_raddr = bad ? '0 : SW'(src);

  // stage 1: aligned with the registered memory read
  logic          s1_v, s1_msg, s1_bad;
  logic [CW-1:0] s1_chan;
  logic [7:0]    s1_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_msg  <= 1'b0;
      s1_bad  <= 1'b0;
      s1_chan <= '0;
      s1_lo   <= '0;
    end else begin
      s1_v    <= issue;
      s1_msg  <= e_msg;
      s1_bad  <= bad;
      s1_chan <= chan;
      s1_lo   <= e_lo;
    end
  end

  // stage 2: registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_byte  <= '0;
    end else begin
      out_valid <= s1_v;
      out_chan  <= s1_chan;
      if (s1_msg)      out_byte <= s1_lo;
      else if (s1_bad) out_byte <= 8'hFF;
      else             out_byte <= mem_rdata;
    end
  end

  // R4: invalid source gives all ones
  p_bad_ff_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !s1_msg && s1_bad) |=> (out_valid && out_byte == 8'hFF));

  // R5: message byte passes unchanged
  p_msg_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_msg) |=> (out_byte == $past(s1_lo)));

  // R9: ascending channel order
  p_order_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> (out_chan == CW'($past(out_chan) + 1'b1)));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NUM_SRC = 384,
  parameter int NUM_OUT = 128,
  localparam int SW = $clog2(NUM_SRC),
  localparam int CW = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         in_byte,
  output logic [SW-1:0]      cur_slot,
  input  logic               dma_en,
  input  logic               cpu_we,
  input  logic               cpu_hi,
  input  logic [CW-1:0]      cpu_addr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  output logic               out_valid,
  output logic [CW-1:0]      out_chan,
  output logic [7:0]         out_byte,
  output logic [NUM_OUT-1:0] xfer_en
);
  logic          wr_bank, swap, primed, issue;
  logic [SW-1:0] slot, raddr;
  logic [7:0]    rdata;
  conn_entry_t   entry;

  tsi_frame_timer #(.NUM_SRC(NUM_SRC)) u_timer (
    .clk(clk), .rst(rst), .slot(slot), .wr_bank(wr_bank),
    .swap(swap), .primed(primed)
  );

  assign cur_slot = slot;
  assign issue    = primed && (slot < SW'(NUM_OUT));

  tsi_data_mem #(.NUM_SRC(NUM_SRC)) u_dmem (
    .clk(clk), .wbank(wr_bank), .waddr(slot), .wdata(in_byte),
    .rbank(~wr_bank), .raddr(raddr), .rdata(rdata)
  );

  tsi_conn_mem #(.NUM_OUT(NUM_OUT)) u_cmem (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_hi(cpu_hi),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .swap(swap), .dma_en(dma_en), .rd_chan(CW'(slot)),
    .rd_entry(entry), .xfer_en(xfer_en)
  );

  tsi_out_sel #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_sel (
    .clk(clk), .rst(rst), .issue(issue), .chan(CW'(slot)),
    .e_msg(entry.msg), .e_a8(entry.a8), .e_lo(entry.lo),
    .mem_raddr(raddr), .mem_rdata(rdata),
    .out_valid(out_valid), .out_chan(out_chan), .out_byte(out_byte)
  );

  // R1: nothing is sent before a full frame has been stored
  p_primed_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> primed);
endmodule

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;
  localparam int NSRC = 384;
  localparam int NOUT = 128;
  localparam int SW = $clog2(NSRC);
  localparam int CW = $clog2(NOUT);

  logic clk = 0, rst = 1;
  logic [7:0] in_byte = 0, cpu_wdata = 0, cpu_rdata, out_byte;
  logic [SW-1:0] cur_slot;
  logic dma_en = 0, cpu_we = 0, cpu_hi = 0, out_valid;
  logic [CW-1:0] cpu_addr = 0, out_chan;
  logic [NOUT-1:0] xfer_en;

  always #5 clk = ~clk;

  tsi_switch #(.NUM_SRC(NSRC), .NUM_OUT(NOUT)) dut (
    .clk(clk), .rst(rst), .in_byte(in_byte), .cur_slot(cur_slot),
    .dma_en(dma_en), .cpu_we(cpu_we), .cpu_hi(cpu_hi), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .out_valid(out_valid),
    .out_chan(out_chan), .out_byte(out_byte), .xfer_en(xfer_en)
  );

  int n_checks = 0, n_err = 0;
  int frame = -1, out_cnt = 0;
  logic [7:0] cur_in [NSRC];
  logic [7:0] prev_in [NSRC];
  logic [7:0] sh_lo [NOUT], act_lo [NOUT];
  logic [2:0] sh_hi [NOUT], act_hi [NOUT];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int fr, input int s);
    return 8'((s * 5) + (fr * 29) + ((s >> 8) * 8'h40) + 1);
  endfunction

  // monitor: frame tracking, input drive, output model
  always @(negedge clk) begin
    if (!rst) begin
      if (cur_slot == 0) begin
        if (frame >= 1) check("R9 per-frame count", out_cnt, NOUT);
        out_cnt = 0;
        frame++;
        for (int i = 0; i < NSRC; i++) prev_in[i] = cur_in[i];
        for (int i = 0; i < NOUT; i++) begin act_lo[i] = sh_lo[i]; act_hi[i] = sh_hi[i]; end
      end
      if (frame == 0) check("R1 no output in first frame", out_valid, 0);
      if (out_valid) begin
        logic [8:0] src;
        logic [7:0] e;
        string rq;
        out_cnt++;
        check("R9 slot timing", out_chan, CW'(cur_slot - 2));
        src = {act_hi[out_chan][0], act_lo[out_chan]};
        if (act_hi[out_chan][2]) begin e = act_lo[out_chan]; rq = "R5 message"; end
        else if (src >= NSRC) begin e = 8'hFF; rq = "R4 invalid"; end
        else begin e = prev_in[src]; rq = src[8] ? "R3 high source" : "R2 switched"; end
        check(rq, out_byte, e);
      end
      in_byte = pat(frame, int'(cur_slot));
      cur_in[cur_slot] = in_byte;
    end
  end

  task automatic wait_slot(input int s);
    do @(negedge clk); while (cur_slot != SW'(s));
  endtask

  task automatic wr(input int ch, input bit hi, input logic [7:0] d);
    do @(negedge clk); while (cur_slot == 0 || cur_slot >= NSRC - 2);
    cpu_we = 1; cpu_hi = hi; cpu_addr = CW'(ch); cpu_wdata = d;
    if (hi) sh_hi[ch] = d[2:0]; else sh_lo[ch] = d;
    @(negedge clk); cpu_we = 0;
  endtask

  task automatic rd(input int ch, input bit hi, output logic [7:0] d);
    cpu_we = 0; cpu_hi = hi; cpu_addr = CW'(ch);
    @(negedge clk); d = cpu_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 xfer_en after reset", xfer_en, 0);
    for (int c = 0; c < NOUT; c += 37) begin
      rd(c, 0, d); check("R1 low cleared", d, 0);
      rd(c, 1, d); check("R1 high cleared", d, 0);
    end
    wait_slot(0); wait_slot(0); wait_slot(0);
  endtask

  task automatic t_switch();
    for (int c = 0; c < NOUT; c++) wr(c, 0, 8'((c * 3 + 1) % 256));
    wait_slot(0); wait_slot(0); wait_slot(0);   // R2, R10 via monitor
  endtask

  task automatic t_high();
    for (int c = 0; c < 16; c++) begin wr(c, 0, 8'(c * 8)); wr(c, 1, 8'h01); end
    wr(16, 0, 8'h7F); wr(16, 1, 8'h01);          // slot 383
    wait_slot(0); wait_slot(0);                   // R3 via monitor
  endtask

  task automatic t_invalid();
    wr(20, 0, 8'h80); wr(20, 1, 8'h01);          // 384
    wr(21, 0, 8'hFF); wr(21, 1, 8'h01);          // 511
    wait_slot(0);
    do @(negedge clk); while (!(out_valid && out_chan == 21));
    check("R4 address 511", out_byte, 8'hFF);
    wait_slot(0);
  endtask

  task automatic t_msg();
    wr(30, 0, 8'h3C); wr(30, 1, 8'h04);
    wr(31, 0, 8'h00); wr(31, 1, 8'h05);
    wait_slot(0);
    do @(negedge clk); while (!(out_valid && out_chan == 30));
    check("R5 message byte", out_byte, 8'h3C);
    @(negedge clk); check("R5 message ignores address", out_byte, 8'h00);
    wait_slot(0);
  endtask

  task automatic t_xfer();
    dma_en = 1;
    wr(5, 1, 8'h02); wr(6, 1, 8'h02);
    @(negedge clk); check("R7 enable deferred", xfer_en, 0);
    wait_slot(3);
    check("R6 gated enable", xfer_en, (NOUT'(1) << 5) | (NOUT'(1) << 6));
    dma_en = 0;
    @(negedge clk); check("R6 global off", xfer_en, 0);
    wr(5, 1, 8'h00); wr(6, 1, 8'h00);
    wait_slot(0);
  endtask

  task automatic t_defer();
    logic [7:0] d;
    wait_slot(5);
    wr(100, 0, 8'hA5); wr(100, 1, 8'h04);
    rd(100, 0, d); check("R8 low readback", d, 8'hA5);
    do @(negedge clk); while (!(out_valid && out_chan == 100));
    check("R7 old entry this frame", out_byte, prev_in[(100 * 3 + 1) % 256]);
    wait_slot(0);
    do @(negedge clk); while (!(out_valid && out_chan == 100));
    check("R7 new entry next frame", out_byte, 8'hA5);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    wr(77, 0, 8'h5A); wr(77, 1, 8'hFF);
    rd(77, 0, d); check("R8 low half", d, 8'h5A);
    rd(77, 1, d); check("R8 high keeps 3 bits", d, 8'h07);
    wr(77, 1, 8'h00);
    rd(77, 1, d); check("R8 high cleared", d, 8'h00);
    wait_slot(0); wait_slot(0);
  endtask

  initial begin
    for (int i = 0; i < NOUT; i++) begin sh_lo[i] = 0; sh_hi[i] = 0; act_lo[i] = 0; act_hi[i] = 0; end
    for (int i = 0; i < NSRC; i++) begin cur_in[i] = 0; prev_in[i] = 0; end
    repeat (4) @(posedge clk);
    #2 rst = 0;
    t_reset();
    t_switch();
    t_high();
    t_invalid();
    t_msg();
    t_xfer();
    t_defer();
    t_readback();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule